// File: doc/BRIEF.md
# Interrupt Aggregator with Masks

This block merges level interrupt requests from six on-chip peripherals onto one host interrupt line. The six sources are two I2C masters, an SPI flash controller, two stream DMA engines and a common-interface controller. Each request is sampled into a read-only status word. A per-source mask selects which requests count. A global enable gates the final output. The host reaches all of this through a small memory-mapped register port.

The mask is never written as a whole. Software sets bits through one alias address and clears them through another, so two agents can change different mask bits without a read-modify-write race. A global status bit shows whether any masked request is pending, whatever the enable holds. An encoded readout names the pending source that software must service first, which saves the handler from scanning the status word. Requests are cleared at each source, never here.

Top module: `irq_agg`

## Requirements
- R1: After reset the mask reads 0, the global enable reads 0 and `irq_o` is 0.
- R2: A read of address 0x00 returns the sampled source levels. The bit positions are I2C master 0 = bit 0, I2C master 1 = bit 1, SPI = bit 2, DMA engine 1 = bit 3, DMA engine 2 = bit 4 and common interface = bit 5. Read data appears on `rdata_o` one cycle after the read request. A source level reaches the status word one cycle after it is applied.
- R3: A write to address 0x08 sets every mask bit that is 1 in the written data and leaves every other mask bit unchanged. The mask reads back at address 0x04.
- R4: A write to address 0x0C clears every mask bit that is 1 in the written data and leaves the rest unchanged. Writing 0xFFFF clears the whole mask in one access.
- R5: Bit 7 of address 0x40 reads 1 exactly when some source is both pending and unmasked. This does not depend on the global enable. The other bits of that address read 0.
- R6: Bit 7 of address 0x50 is the global enable. It reads back in bit 7, and the other bits read 0.
- R7: `irq_o` is a register equal to (global enable AND any masked pending source). It falls at the same clock edge that stores a 0 into the enable, and it falls one cycle after the last masked pending request is removed from the status word.
- R8: Writing 0x80 to address 0x50 while a masked request is pending raises `irq_o` at the edge that stores the enable.
- R9: Address 0x10 reads bit 7 = 1 when any masked source is pending. In that case bits 2:0 hold the lowest-numbered masked pending source, following the service order I2C0, I2C1, SPI, DMA1, DMA2, CI. With nothing pending the address reads 0.
- R10: A request from a masked-off source has no effect on `irq_o`, on the global status bit or on the encoded readout.
- R11: Writes to the read-only addresses 0x00, 0x40 and 0x10 change neither the mask, the enable nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level requests from the sources |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions assume a register access lasts a single cycle and carries one address, so a set and a clear of the mask never happen in the same cycle. They also assume source levels change only between clock edges. The bench drives every access and every source change on the falling clock edge, and it holds each access strobe for exactly one cycle. Before checking `irq_o` or the status word, it waits out the sampling stage that follows each source change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned EN_BIT = 7;
  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_MASK   = 8'h04;
  localparam logic [7:0] OFS_MSET   = 8'h08;
  localparam logic [7:0] OFS_MCLR   = 8'h0C;
  localparam logic [7:0] OFS_TOP    = 8'h10;
  localparam logic [7:0] OFS_GSTAT  = 8'h40;
  localparam logic [7:0] OFS_GEN    = 8'h50;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] bits_i,
  input  logic               en_bit_i,
  output logic [NUM_SRC-1:0] mask_d_o,
  output logic [NUM_SRC-1:0] mask_q_o,
  output logic               en_d_o,
  output logic               en_q_o
);
  import irq_agg_pkg::*;
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_MCLR);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_GEN);

  always_comb begin
    mask_d_o = mask_q_o;
    en_d_o   = en_q_o;
    if (wr_i) begin
      if (addr_i == A_SET) mask_d_o = mask_q_o | bits_i;
      if (addr_i == A_CLR) mask_d_o = mask_q_o & ~bits_i;
      if (addr_i == A_EN)  en_d_o   = en_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= '0;
      en_q_o   <= 1'b0;
    end else begin
      mask_q_o <= mask_d_o;
      en_q_o   <= en_d_o;
    end
  end
endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio #(
  parameter int unsigned NUM_SRC = 6,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign vld_o = |pend_i;
endmodule

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  import irq_agg_pkg::*;
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_TOP   = ADDR_W'(OFS_TOP);
  localparam logic [ADDR_W-1:0] A_GSTAT = ADDR_W'(OFS_GSTAT);
  localparam logic [ADDR_W-1:0] A_GEN   = ADDR_W'(OFS_GEN);

  logic [NUM_SRC-1:0] status_q, mask_q, mask_d, pend;
  logic               en_q, en_d, top_vld, irq_q;
  logic [IDX_W-1:0]   top_idx;
  logic [REG_W-1:0]   rdata_d, rdata_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= src_i;
  end

  irq_agg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (req_i & we_i),
    .addr_i   (addr_i),
    .bits_i   (wdata_i[NUM_SRC-1:0]),
    .en_bit_i (wdata_i[EN_BIT]),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q),
    .en_d_o   (en_d),
    .en_q_o   (en_q)
  );

  assign pend = status_q & mask_q;

  irq_agg_prio #(.NUM_SRC(NUM_SRC)) i_prio (
    .pend_i (pend),
    .vld_o  (top_vld),
    .idx_o  (top_idx)
  );

  // use next-state values so an enable or mask write acts at its own edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_d & (|(status_q & mask_d));
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_d = '0;
    if (addr_i == A_STAT)  rdata_d = REG_W'(status_q);
    if (addr_i == A_MASK)  rdata_d = REG_W'(mask_q);
    if (addr_i == A_TOP)   rdata_d = (REG_W'(top_vld) << EN_BIT) | (top_vld ? REG_W'(top_idx) : '0);
    if (addr_i == A_GSTAT) rdata_d = REG_W'(top_vld) << EN_BIT;
    if (addr_i == A_GEN)   rdata_d = REG_W'(en_q) << EN_BIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rdata_d;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic               irq_o,
  input logic               en_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] pend,
  input logic               top_vld,
  input logic [IDX_W-1:0]   top_idx
);
  import irq_agg_pkg::*;
  logic [NUM_SRC-1:0] below;
  logic wr_set, wr_clr, wr_en_off;

  assign below     = NUM_SRC'((1 << top_idx) - 1);
  assign wr_set    = req_i && we_i && addr_i == ADDR_W'(OFS_MSET);
  assign wr_clr    = req_i && we_i && addr_i == ADDR_W'(OFS_MCLR);
  assign wr_en_off = req_i && we_i && addr_i == ADDR_W'(OFS_GEN) && !wdata_i[EN_BIT];

  AST_MASK_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]))); // R3
  AST_MASK_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == '0)); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_q); // R7
  AST_EN_OFF_QUIETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_off |=> !irq_o); // R7
  AST_TOP_IS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld |-> pend[top_idx]); // R9
  AST_TOP_IS_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld |-> ((pend & below) == '0)); // R9
  AST_NONE_MEANS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !top_vld |-> (pend == '0)); // R10
endmodule

bind irq_agg irq_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .mask_q  (mask_q),
  .pend    (pend),
  .top_vld (top_vld),
  .top_idx (top_idx)
);

// File: tb/test_irq_agg.sv
module test_irq_agg;
  localparam int unsigned NUM_SRC = 6;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NUM_SRC-1:0] src_i = '0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic irq_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_agg #(.NUM_SRC(NUM_SRC), .ADDR_W(8)) i_irq_agg (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic drive_src(input logic [NUM_SRC-1:0] s);
    src_i = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(8'h04, d); check("R1 mask", d, 32'h0);
    rd(8'h50, d); check("R1 enable", d, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    drive_src(6'b101010);
    rd(8'h00, d); check("R2 status", d, 32'h2A);
    check("R10 irq masked", {31'b0, irq_o}, 32'h0);
    rd(8'h40, d); check("R10 gstat masked", d, 32'h0);
    rd(8'h10, d); check("R10 top masked", d, 32'h0);
  endtask

  task automatic t_mask_set;
    logic [31:0] d;
    wr(8'h08, 32'h08);
    rd(8'h04, d); check("R3 set one", d, 32'h08);
    wr(8'h08, 32'h21);
    rd(8'h04, d); check("R3 set keeps", d, 32'h29);
    rd(8'h40, d); check("R5 gstat no enable", d, 32'h80);
    check("R7 irq no enable", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(8'h50, 32'h80);
    check("R7 irq on", {31'b0, irq_o}, 32'h1);
    rd(8'h50, d); check("R6 enable read", d, 32'h80);
    wr(8'h50, 32'h0);
    check("R7 irq off at write", {31'b0, irq_o}, 32'h0);
    wr(8'h50, 32'h80);
    check("R8 irq restored", {31'b0, irq_o}, 32'h1);
    wr(8'h50, 32'hFF7F);
    rd(8'h50, d); check("R6 only bit7", d, 32'h0);
    check("R7 irq off", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(8'h08, 32'h3F);
    drive_src(6'h30);
    rd(8'h10, d); check("R9 dma2 first", d, 32'h84);
    drive_src(6'h3F);
    rd(8'h10, d); check("R9 i2c0 first", d, 32'h80);
    drive_src(6'h0C);
    rd(8'h10, d); check("R9 spi first", d, 32'h82);
    drive_src(6'h20);
    rd(8'h10, d); check("R9 ci only", d, 32'h85);
    wr(8'h0C, 32'h20);
    rd(8'h10, d); check("R10 top masked off", d, 32'h0);
    rd(8'h40, d); check("R5 gstat clear", d, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(8'h08, 32'h3F);
    wr(8'h0C, 32'h05);
    rd(8'h04, d); check("R4 partial clear", d, 32'h3A);
    wr(8'h50, 32'h80);
    check("R7 irq pending ci", {31'b0, irq_o}, 32'h1);
    wr(8'h0C, 32'hFFFF);
    rd(8'h04, d); check("R4 clear all", d, 32'h0);
    check("R4 irq after clear all", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_src_drop;
    wr(8'h08, 32'h02);
    drive_src(6'h02);
    check("R7 irq from i2c1", {31'b0, irq_o}, 32'h1);
    drive_src(6'h00);
    check("R7 irq follows drop", {31'b0, irq_o}, 32'h0);
    wr(8'h0C, 32'hFFFF);
    wr(8'h50, 32'h0);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    drive_src(6'h01);
    wr(8'h00, 32'hFFFF);
    wr(8'h40, 32'hFFFF);
    wr(8'h10, 32'hFFFF);
    rd(8'h04, d); check("R11 mask untouched", d, 32'h0);
    rd(8'h50, d); check("R11 enable untouched", d, 32'h0);
    check("R11 irq untouched", {31'b0, irq_o}, 32'h0);
    rd(8'h00, d); check("R11 status untouched", d, 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_status();
    t_mask_set();
    t_enable();
    t_prio();
    t_clear();
    t_src_drop();
    t_readonly();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule